// File: doc/BRIEF.md
# Parallel Flash Command Mode Interpreter

This block is the command front end of a parallel NOR-style flash memory. It watches single-cycle bus write strobes carrying an address and a data byte and keeps track of the read mode the device is in. There are four modes: array read, identifier (autoselect), CFI query, and erase-busy. It also recognises the unlock sequences that enter autoselect and that start a chip erase. When a chip erase starts, it raises a one-cycle start pulse to an external erase engine. It then stays busy until that engine reports completion.

A bus read returns different data in each mode, chosen from the read address. Array read returns a stub data pattern. Autoselect returns the manufacturer and device identifiers. CFI query returns a small stub query table. Erase-busy returns a status byte. The CFI query mode remembers whether it was entered from array read or from autoselect, so a reset takes the device back one level only. Once an erase has started, every write is ignored until the erase engine finishes.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, `mode` is 0 (array read) and `erase_start` is low.
- R2: In array read mode (`mode`=0), `rd_data` is the read address low byte XOR 0x5A until a chip erase has completed; after that it is 0xFF.
- R3: The writes AA@555, then 55@2AA, then 90@555 put the block in autoselect mode (`mode`=1) from array read or autoselect. In this mode `rd_data` is MFR_ID at address offset 0, DEV_ID at offset 1, and 0x00 at the other two values of address bits [1:0].
- R4: A write of 0x98 to address 0x55 in array read or autoselect mode enters CFI query mode (`mode`=2) on the next cycle. In this mode `rd_data` is 0x51 at address 0x10, 0x52 at 0x11, 0x59 at 0x12, and 0x00 elsewhere.
- R5: A write of 0xF0 to any address is a reset. In CFI query mode it returns to the mode the query was entered from. In autoselect it returns to array read. So reaching array read from a query entered via autoselect takes two resets.
- R6: In CFI query mode, every write other than 0xF0 is ignored. A repeated 0x98@55 does not change which mode a later reset returns to.
- R7: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 start a chip erase. After the edge that takes the last write, `erase_start` is high for exactly one cycle and `mode` is 3.
- R8: A write that does not match the next expected cycle of a sequence abandons that sequence. The mode is unchanged, and the sequence must restart from its first cycle.
- R9: While `mode` is 3, every write is ignored, including 0xF0, 0xB0 and 0x98@55. The mode leaves 3 only on `erase_done`.
- R10: While `mode` is 3, `rd_data` is a status byte. Bit 7 is 0, bit 3 is 1, and bit 6 flips after every cycle with `rd_en` high. All other bits are 0.
- R11: `erase_done` in mode 3 returns the block to array read on the next cycle; outside mode 3 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data; commands use bits [7:0] |
| rd_en | input | 1 | Bus read strobe; advances the status toggle bit |
| erase_done | input | 1 | Completion flag from the erase engine |
| rd_data | output | DATA_W | Read data, chosen by the current mode |
| mode | output | 2 | 0 array, 1 autoselect, 2 CFI query, 3 erase busy |
| erase_start | output | 1 | One-cycle pulse that starts the erase engine |

## Verification
The bound checker verifies these properties on every cycle:
- a CFI entry write takes effect on the next cycle;
- a reset in query mode leaves it;
- busy mode holds until completion;
- the start pulse lasts one cycle and coincides with busy;
- the fixed status bits are correct.

Other behaviour depends on history across several writes, so only the directed scenarios show it. This covers the sequence matching and abort behaviour, the remembered return level after a nested query, the identifier and query table contents, the status toggle across reads, and the erased array pattern.

// File: rtl/flash_cmd_front.sv
module flash_cmd_front #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'hD7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              erase_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        mode,
  output logic              erase_start
);

  localparam logic [1:0] M_ARR  = 2'd0;
  localparam logic [1:0] M_AUTO = 2'd1;
  localparam logic [1:0] M_CFI  = 2'd2;
  localparam logic [1:0] M_BUSY = 2'd3;

  localparam logic [ADDR_W-1:0] A_555 = ADDR_W'(11'h555);
  localparam logic [ADDR_W-1:0] A_2AA = ADDR_W'(11'h2AA);
  localparam logic [ADDR_W-1:0] A_55  = ADDR_W'(11'h055);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_E3, S_E4, S_E5} seq_t;

  seq_t       seq, seq_nx;
  logic       from_auto, erased, tgl;
  logic       go_auto, go_erase;
  logic [7:0] cmd;

  assign cmd = wdata[7:0];

  always_comb begin
    seq_nx   = S_IDLE;
    go_auto  = 1'b0;
    go_erase = 1'b0;
    unique case (seq)
      S_IDLE: if (cmd == 8'hAA && addr == A_555) seq_nx = S_U1;
      S_U1:   if (cmd == 8'h55 && addr == A_2AA) seq_nx = S_U2;
      S_U2: begin
        if (cmd == 8'h90 && addr == A_555) go_auto = 1'b1;
        else if (cmd == 8'h80 && addr == A_555) seq_nx = S_E3;
      end
      S_E3:   if (cmd == 8'hAA && addr == A_555) seq_nx = S_E4;
      S_E4:   if (cmd == 8'h55 && addr == A_2AA) seq_nx = S_E5;
      S_E5:   if (cmd == 8'h10 && addr == A_555) go_erase = 1'b1;
      default: seq_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode        <= M_ARR;
      from_auto   <= 1'b0;
      seq         <= S_IDLE;
      erase_start <= 1'b0;
      erased      <= 1'b0;
      tgl         <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      if (mode == M_BUSY) begin
        if (rd_en) tgl <= ~tgl;
        if (erase_done) begin
          mode   <= M_ARR;
          erased <= 1'b1;
        end
      end else if (wr_en) begin
        if (cmd == 8'hF0) begin
          seq <= S_IDLE;
          if (mode == M_CFI) mode <= from_auto ? M_AUTO : M_ARR;
          else mode <= M_ARR;
        end else if (mode == M_CFI) begin
          seq <= S_IDLE;
        end else if (cmd == 8'h98 && addr == A_55) begin
          from_auto <= (mode == M_AUTO);
          mode      <= M_CFI;
          seq       <= S_IDLE;
        end else begin
          seq <= seq_nx;
          if (go_auto) mode <= M_AUTO;
          if (go_erase) begin
            mode        <= M_BUSY;
            erase_start <= 1'b1;
            tgl         <= 1'b0;
          end
        end
      end
    end
  end

  logic [7:0] arr_b, id_b, cfi_b, st_b, out_b;

  assign arr_b = erased ? 8'hFF : (addr[7:0] ^ 8'h5A);
  assign id_b  = (addr[1:0] == 2'd0) ? MFR_ID :
                 (addr[1:0] == 2'd1) ? DEV_ID : 8'h00;
  assign cfi_b = (addr == ADDR_W'(8'h10)) ? 8'h51 :
                 (addr == ADDR_W'(8'h11)) ? 8'h52 :
                 (addr == ADDR_W'(8'h12)) ? 8'h59 : 8'h00;
  assign st_b  = {1'b0, tgl, 2'b00, 1'b1, 3'b000};

  always_comb begin
    unique case (mode)
      M_ARR:   out_b = arr_b;
      M_AUTO:  out_b = id_b;
      M_CFI:   out_b = cfi_b;
      default: out_b = st_b;
    endcase
  end

  assign rd_data = DATA_W'(out_b);

endmodule

// File: rtl/flash_cmd_front_chk.sv
module flash_cmd_front_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              erase_done,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        mode,
  input logic              erase_start
);

  p_cfi_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[7:0] == 8'h98 && addr == ADDR_W'(11'h055) && mode <= 2'd1)
      |=> mode == 2'd2);

  p_cfi_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[7:0] == 8'hF0 && mode == 2'd2) |=> mode != 2'd2);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !erase_done) |=> mode == 2'd3);

  p_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && erase_done) |=> mode == 2'd0);

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> mode == 2'd3);

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 |-> (rd_data[7] == 1'b0 && rd_data[3] == 1'b1));

endmodule

bind flash_cmd_front flash_cmd_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .erase_done(erase_done), .rd_data(rd_data), .mode(mode), .erase_start(erase_start)
);

// File: tb/flash_cmd_front_tb.sv
module flash_cmd_front_tb;
  localparam int AW = 11;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          rd_en = 1'b0;
  logic          erase_done = 1'b0;
  logic [DW-1:0] rd_data;
  logic [1:0]    mode;
  logic          erase_start;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .erase_done(erase_done), .rd_data(rd_data), .mode(mode),
    .erase_start(erase_start)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = DW'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    #1 v = int'(rd_data);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic unlock_auto();
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h90);
  endtask

  task automatic t_reset();
    check("R1 mode", int'(mode), 0);
    check("R1 erase_start", int'(erase_start), 0);
  endtask

  task automatic t_array();
    int v;
    rd('h033, v); check("R2 array 033", v, 'h33 ^ 'h5A);
    rd('h0C4, v); check("R2 array 0C4", v, 'hC4 ^ 'h5A);
    wr('h123, 'hF0); check("R5 reset in array", int'(mode), 0);
  endtask

  task automatic t_autosel();
    int v;
    unlock_auto(); check("R3 enter", int'(mode), 1);
    rd('h000, v); check("R3 mfr", v, 'h20);
    rd('h001, v); check("R3 dev", v, 'hD7);
    rd('h002, v); check("R3 other", v, 0);
    wr('h000, 'hF0); check("R5 auto->array", int'(mode), 0);
  endtask

  task automatic t_cfi_array();
    int v;
    wr('h055, 'h98); check("R4 enter from array", int'(mode), 2);
    rd('h010, v); check("R4 Q", v, 'h51);
    rd('h011, v); check("R4 R", v, 'h52);
    rd('h012, v); check("R4 Y", v, 'h59);
    rd('h013, v); check("R4 other", v, 0);
    wr('h555, 'hAA); check("R6 ignored in cfi", int'(mode), 2);
    wr('h000, 'hF0); check("R5 cfi->array", int'(mode), 0);
  endtask

  task automatic t_cfi_nested();
    unlock_auto();
    wr('h055, 'h98); check("R4 enter from auto", int'(mode), 2);
    wr('h055, 'h98); check("R6 repeat entry", int'(mode), 2);
    wr('h000, 'hF0); check("R5 first reset", int'(mode), 1);
    wr('h000, 'hF0); check("R5 second reset", int'(mode), 0);
  endtask

  task automatic t_abort();
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h30);
    check("R8 bad last cycle start", int'(erase_start), 0);
    check("R8 bad last cycle mode", int'(mode), 0);
    wr('h555, 'h10);
    check("R8 no restart mid-seq", int'(erase_start), 0);
    wr('h555, 'hAA); wr('h2AA, 'h56); wr('h555, 'h90);
    check("R8 bad unlock", int'(mode), 0);
  endtask

  task automatic t_erase();
    int v1, v2;
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h10);
    check("R7 start pulse", int'(erase_start), 1);
    check("R7 busy", int'(mode), 3);
    @(negedge clk);
    check("R7 pulse ends", int'(erase_start), 0);
    wr('h000, 'hF0); check("R9 reset ignored", int'(mode), 3);
    wr('h000, 'hB0); check("R9 suspend ignored", int'(mode), 3);
    wr('h055, 'h98); check("R9 cfi ignored", int'(mode), 3);
    rd('h000, v1); rd('h000, v2);
    check("R10 status fixed bits", v1 & 'hBF, 'h08);
    check("R10 toggle", (v1 ^ v2) & 'h40, 'h40);
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    check("R11 back to array", int'(mode), 0);
    rd('h033, v1); check("R2 erased reads FF", v1, 'hFF);
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    check("R11 done ignored outside busy", int'(mode), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_array();
    t_autosel();
    t_cfi_array();
    t_cfi_nested();
    t_abort();
    t_erase();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule